// File: doc/BRIEF.md
# Polled Sensor Conversion Sequencer

This block measures up to four on-die sensing points without owning a converter. A free-running period timer starts a measurement round. During the round the block acts as a simple bus master. For each enabled point it can first write a sensor-select code to the sensor multiplexer. It can then write a channel value to the converter's channel register. After that it writes an enable value to start the conversion, and it keeps reading a status word until a chosen bit shows that the conversion has finished. The block then takes the result from that same word, shifts it, and stores it in the point's 12-bit result register.

Software programs every bus address, data value, bit position, polarity and shift at run time through a register-write port, so the same block can drive converters with different register layouts. If a point never reports valid within the timeout, the block flags an error for that point and moves on to the next one.

Top module: `stc_sensor_sequencer`

## Requirements
- R1: A round starts every 256 × unit × interval clock cycles, where unit is configuration word 0 bits 9:0 and interval is word 1 bits 9:0. A zero in either field counts as one. A write to word 0 or word 1 restarts the timer.
- R2: Only the points whose bits are set in the enable mask (word 2, bit i for point i) are measured, in ascending index order. The result registers of points that are not enabled keep their values.
- R3: When write-control bit 0 (word 3) is set, the first transaction for each point writes that point's sensor code (word 16+i, 5 bits, so values up to 31 such as 16) to the sensor-mux address (word 4).
- R4: When write-control bit 1 is set, the block next writes the channel value (word 6) to the channel address (word 5). For every point it then writes the enable value (word 8) to the enable address (word 7). With both control bits clear, the enable write is the first transaction.
- R5: After the enable write, the block reads the valid address (word 9). The read counts as valid when bit[pos] equals the polarity, where pos is word 10 bits 4:0 and the polarity is word 10 bit 5 (1 = active high).
- R6: On a valid read, the stored result is bits 11:0 of the same read word shifted right by word 11 bits 4:0.
- R7: After an invalid read, the block waits max(poll,1) cycles before it reads again. The poll value is word 12. Consecutive read grants are therefore poll+1 cycles apart when the bus answers at once.
- R8: When an invalid read completes after the timeout count (word 13) of polling cycles, the point's error flag sets, its result is kept, and the next enabled point follows. A later valid result for that point clears the flag.
- R9: A period expiry while a round is in progress is ignored. A round never restarts from its first point before it has finished.
- R10: A bus request holds its address and direction until acknowledged, and only one request is outstanding at a time.
- R11: Each stored result raises that point's update pulse for exactly one cycle. At most one point updates per cycle, and only right after a completed read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration word index |
| cfg_wdata | input | 32 | Configuration write data |
| bus_req | output | 1 | Bus transaction request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 32 | Transaction address |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Transaction completes in this cycle |
| bus_rdata | input | 32 | Read data, valid with bus_ack |
| res_data | output | 48 | Point i result in bits 12i+11:12i |
| res_upd | output | 4 | One-cycle pulse when a point's result is stored |
| res_err | output | 4 | Per-point timeout flag |

## Verification
The period timer runs on its own, so a period expiry can land in the same cycle as a long polling phase of a round that is still running. The bench provokes this by holding the first point invalid for longer than the period, using a timeout beyond one period. It then judges from the log of sensor-mux writes that the codes alternate 0,1,0,1 and that successive round starts are two full periods apart. A second overlap, between a timeout decision and the final poll read, is judged by checking that the error flag is set while the stored result stays unchanged.

// File: rtl/stc_pkg.sv
package stc_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_PNP, ST_MUX, ST_EN, ST_RD, ST_WAIT
   } stc_state_e;

   localparam logic [4:0] CA_UNIT  = 5'd0;
   localparam logic [4:0] CA_INTV  = 5'd1;
   localparam logic [4:0] CA_MASK  = 5'd2;
   localparam logic [4:0] CA_WCTL  = 5'd3;
   localparam logic [4:0] CA_PNPA  = 5'd4;
   localparam logic [4:0] CA_MUXA  = 5'd5;
   localparam logic [4:0] CA_MUXV  = 5'd6;
   localparam logic [4:0] CA_ENA   = 5'd7;
   localparam logic [4:0] CA_ENV   = 5'd8;
   localparam logic [4:0] CA_VLDA  = 5'd9;
   localparam logic [4:0] CA_VLDM  = 5'd10;
   localparam logic [4:0] CA_SHFT  = 5'd11;
   localparam logic [4:0] CA_POLL  = 5'd12;
   localparam logic [4:0] CA_TMO   = 5'd13;
   localparam int unsigned CA_CODE0 = 16;
endpackage

// File: rtl/stc_period_timer.sv
module stc_period_timer #(
   parameter int unsigned UNIT_W = 10,
   parameter int unsigned PRE_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic [UNIT_W-1:0] unit,
   input  logic [UNIT_W-1:0] intv,
   output logic              tick
);
   localparam int unsigned CW = 2*UNIT_W + PRE_W;

   logic [UNIT_W-1:0] u_eff, v_eff;
   logic [CW-1:0]     prod, limit, cnt;

   assign u_eff = (unit == '0) ? UNIT_W'(1) : unit;
   assign v_eff = (intv == '0) ? UNIT_W'(1) : intv;
   assign prod  = CW'(u_eff) * CW'(v_eff);
   assign limit = (prod << PRE_W) - CW'(1);
   assign tick  = (cnt == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt <= '0;
      else if (restart)       cnt <= '0;
      else if (cnt >= limit)  cnt <= '0;
      else                    cnt <= cnt + CW'(1);
   end
endmodule

// File: rtl/stc_point_pick.sv
module stc_point_pick #(
   parameter int unsigned NPTS  = 4,
   parameter int unsigned IDX_W = 2
) (
   input  logic [NPTS-1:0] mask,
   input  logic [IDX_W:0]  from,
   output logic            found,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = NPTS-1; i >= 0; i--) begin
         if (mask[i] && (i >= int'(from))) begin
            found = 1'b1;
            idx   = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/stc_extract.sv
module stc_extract #(
   parameter int unsigned DW    = 32,
   parameter int unsigned RES_W = 12
) (
   input  logic [DW-1:0]    word,
   input  logic [5:0]       vmask,
   input  logic [4:0]       shift,
   output logic             valid,
   output logic [RES_W-1:0] res
);
   logic [DW-1:0] shifted;

   assign shifted = word >> shift;
   assign valid   = (word[vmask[4:0]] == vmask[5]);

   if (RES_W == DW) begin : g_full
      assign res = shifted;
   end else begin : g_trunc
      assign res = shifted[RES_W-1:0];
   end
endmodule

// File: rtl/stc_sensor_sequencer.sv
module stc_sensor_sequencer
   import stc_pkg::*;
#(
   parameter int unsigned NPTS   = 4,
   parameter int unsigned AW     = 32,
   parameter int unsigned DW     = 32,
   parameter int unsigned RES_W  = 12,
   parameter int unsigned CODE_W = 5,
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned UNIT_W = 10
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_we,
   input  logic [4:0]            cfg_addr,
   input  logic [31:0]           cfg_wdata,
   output logic                  bus_req,
   output logic                  bus_we,
   output logic [AW-1:0]         bus_addr,
   output logic [DW-1:0]         bus_wdata,
   input  logic                  bus_ack,
   input  logic [DW-1:0]         bus_rdata,
   output logic [NPTS*RES_W-1:0] res_data,
   output logic [NPTS-1:0]       res_upd,
   output logic [NPTS-1:0]       res_err
);
   localparam int unsigned IDX_W = (NPTS > 1) ? $clog2(NPTS) : 1;

   if (NPTS < 1 || NPTS > 16) begin : g_bad_npts
      $error("NPTS must be 1..16");
   end
   if (AW > 32 || DW > 32 || CNT_W > 32 || UNIT_W > 32) begin : g_bad_width
      $error("bus and counter widths are limited to the 32-bit config word");
   end
   if (RES_W > DW || CODE_W > DW) begin : g_bad_res
      $error("result and code widths must fit the bus data width");
   end

   // configuration
   logic [UNIT_W-1:0] r_unit, r_intv;
   logic [NPTS-1:0]   r_mask;
   logic [1:0]        r_wctl;
   logic [AW-1:0]     r_pnpa, r_muxa, r_ena, r_vlda;
   logic [DW-1:0]     r_muxv, r_env;
   logic [5:0]        r_vldm;
   logic [4:0]        r_shift;
   logic [CNT_W-1:0]  r_poll, r_tmo;
   logic [CODE_W-1:0] r_code [NPTS];
   logic              cfg_unused;

   assign cfg_unused = ^cfg_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         r_unit <= '0; r_intv <= '0; r_mask <= '0; r_wctl <= '0;
         r_pnpa <= '0; r_muxa <= '0; r_ena <= '0; r_vlda <= '0;
         r_muxv <= '0; r_env <= '0; r_vldm <= 6'h20; r_shift <= '0;
         r_poll <= '0; r_tmo <= '1;
         for (int i = 0; i < NPTS; i++) r_code[i] <= '0;
      end else if (cfg_we) begin
         case (cfg_addr)
            CA_UNIT: r_unit  <= cfg_wdata[UNIT_W-1:0];
            CA_INTV: r_intv  <= cfg_wdata[UNIT_W-1:0];
            CA_MASK: r_mask  <= cfg_wdata[NPTS-1:0];
            CA_WCTL: r_wctl  <= cfg_wdata[1:0];
            CA_PNPA: r_pnpa  <= cfg_wdata[AW-1:0];
            CA_MUXA: r_muxa  <= cfg_wdata[AW-1:0];
            CA_MUXV: r_muxv  <= cfg_wdata[DW-1:0];
            CA_ENA:  r_ena   <= cfg_wdata[AW-1:0];
            CA_ENV:  r_env   <= cfg_wdata[DW-1:0];
            CA_VLDA: r_vlda  <= cfg_wdata[AW-1:0];
            CA_VLDM: r_vldm  <= cfg_wdata[5:0];
            CA_SHFT: r_shift <= cfg_wdata[4:0];
            CA_POLL: r_poll  <= cfg_wdata[CNT_W-1:0];
            CA_TMO:  r_tmo   <= cfg_wdata[CNT_W-1:0];
            default: ;
         endcase
         for (int i = 0; i < NPTS; i++)
            if (cfg_addr == 5'(CA_CODE0 + i)) r_code[i] <= cfg_wdata[CODE_W-1:0];
      end
   end

   // period timer
   logic tick;
   stc_period_timer #(.UNIT_W(UNIT_W), .PRE_W(8)) i_timer (
      .clk(clk), .rst_n(rst_n),
      .restart(cfg_we && (cfg_addr == CA_UNIT || cfg_addr == CA_INTV)),
      .unit(r_unit), .intv(r_intv), .tick(tick)
   );

   // sequencing state
   stc_state_e       state;
   logic [IDX_W-1:0] cur;
   logic [CNT_W-1:0] poll_cnt, tmo_cnt;
   logic [RES_W-1:0] res_q [NPTS];

   logic [IDX_W:0]   pk_from;
   logic             pk_found;
   logic [IDX_W-1:0] pk_idx;
   assign pk_from = (state == ST_IDLE) ? '0 : ((IDX_W+1)'(cur) + 1'b1);

   stc_point_pick #(.NPTS(NPTS), .IDX_W(IDX_W)) i_pick (
      .mask(r_mask), .from(pk_from), .found(pk_found), .idx(pk_idx)
   );

   logic             ex_valid;
   logic [RES_W-1:0] ex_res;
   stc_extract #(.DW(DW), .RES_W(RES_W)) i_extract (
      .word(bus_rdata), .vmask(r_vldm), .shift(r_shift),
      .valid(ex_valid), .res(ex_res)
   );

   stc_state_e first_st;
   logic       timed_out;
   assign first_st  = r_wctl[0] ? ST_PNP : (r_wctl[1] ? ST_MUX : ST_EN);
   assign timed_out = (tmo_cnt >= r_tmo);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE; cur <= '0; poll_cnt <= '0; tmo_cnt <= '0;
         res_upd <= '0; res_err <= '0;
         for (int i = 0; i < NPTS; i++) res_q[i] <= '0;
      end else begin
         res_upd <= '0;
         if (state == ST_RD || state == ST_WAIT)
            if (tmo_cnt != '1) tmo_cnt <= tmo_cnt + 1'b1;
         case (state)
            ST_IDLE: if (tick && pk_found) begin
               cur   <= pk_idx;
               state <= first_st;
            end
            ST_PNP: if (bus_ack) state <= r_wctl[1] ? ST_MUX : ST_EN;
            ST_MUX: if (bus_ack) state <= ST_EN;
            ST_EN:  if (bus_ack) begin
               state   <= ST_RD;
               tmo_cnt <= '0;
            end
            ST_RD: if (bus_ack) begin
               if (ex_valid) begin
                  res_q[cur]   <= ex_res;
                  res_upd[cur] <= 1'b1;
                  res_err[cur] <= 1'b0;
               end else if (timed_out) begin
                  res_err[cur] <= 1'b1;
               end
               if (ex_valid || timed_out) begin
                  if (pk_found) begin
                     cur   <= pk_idx;
                     state <= first_st;
                  end else begin
                     state <= ST_IDLE;
                  end
               end else begin
                  state    <= ST_WAIT;
                  poll_cnt <= CNT_W'(1);
               end
            end
            ST_WAIT: begin
               if (poll_cnt >= r_poll) state <= ST_RD;
               else                    poll_cnt <= poll_cnt + 1'b1;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // bus drive
   always_comb begin
      bus_req   = 1'b1;
      bus_we    = 1'b1;
      bus_addr  = '0;
      bus_wdata = '0;
      case (state)
         ST_PNP: begin bus_addr = r_pnpa; bus_wdata = DW'(r_code[cur]); end
         ST_MUX: begin bus_addr = r_muxa; bus_wdata = r_muxv; end
         ST_EN:  begin bus_addr = r_ena;  bus_wdata = r_env;  end
         ST_RD:  begin bus_addr = r_vlda; bus_we = 1'b0; end
         default: begin bus_req = 1'b0; bus_we = 1'b0; end
      endcase
   end

   for (genvar g = 0; g < NPTS; g++) begin : g_res
      assign res_data[g*RES_W +: RES_W] = res_q[g];
   end
endmodule

// File: rtl/stc_sensor_sequencer_chk.sv
module stc_sensor_sequencer_chk #(
   parameter int unsigned NPTS  = 4,
   parameter int unsigned AW    = 32,
   parameter int unsigned RES_W = 12
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  cfg_we,
   input logic                  bus_req,
   input logic                  bus_we,
   input logic [AW-1:0]         bus_addr,
   input logic                  bus_ack,
   input logic [NPTS*RES_W-1:0] res_data,
   input logic [NPTS-1:0]       res_upd,
   input logic [NPTS-1:0]       res_err
);
   // R10: an unacknowledged request stays up with the same address and direction
   p_req_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ack && !cfg_we) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));

   // R11: at most one point updates per cycle
   p_upd_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(res_upd));

   // R11: an update follows a completed read
   p_upd_after_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (res_upd != '0) |-> $past(bus_ack && !bus_we));

   // R8: results change only together with an update pulse
   p_result_needs_update_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(res_data) |-> (res_upd != '0));

   // R8: a newly raised error never comes with a stored result
   p_new_err_no_update_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((res_err & ~$past(res_err)) != '0) |-> (res_upd == '0));
endmodule

bind stc_sensor_sequencer stc_sensor_sequencer_chk #(
   .NPTS(NPTS), .AW(AW), .RES_W(RES_W)
) i_chk (
   .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .bus_req(bus_req),
   .bus_we(bus_we), .bus_addr(bus_addr), .bus_ack(bus_ack),
   .res_data(res_data), .res_upd(res_upd), .res_err(res_err)
);

// File: tb/test_stc_sensor_sequencer.sv
`timescale 1ns/1ps
module test_stc_sensor_sequencer;
   localparam logic [31:0] A_PNP = 32'h1000_0604;
   localparam logic [31:0] A_MUX = 32'h2000_000C;
   localparam logic [31:0] A_EN  = 32'h2000_0008;
   localparam logic [31:0] A_VLD = 32'h2000_0040;
   localparam logic [31:0] V_MUX = 32'h0000_0800;
   localparam logic [31:0] V_EN  = 32'h0000_0A00;
   localparam int LOGN = 2048;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [4:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic        bus_req, bus_we;
   logic [31:0] bus_addr, bus_wdata;
   logic        bus_ack = 1'b0;
   logic [31:0] bus_rdata = '0;
   logic [47:0] res_data;
   logic [3:0]  res_upd, res_err;

   stc_sensor_sequencer i_stc_sensor_sequencer (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .bus_req(bus_req), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
      .bus_rdata(bus_rdata), .res_data(res_data), .res_upd(res_upd),
      .res_err(res_err)
   );

   always #2.5 clk = ~clk;

   int checks = 0;
   int errors = 0;
   longint cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   // bus slave model and transaction log
   logic [31:0] lg_addr [LOGN];
   logic [31:0] lg_data [LOGN];
   logic        lg_we   [LOGN];
   longint      lg_cyc  [LOGN];
   int          n_tx = 0;
   int          last_code = -1;
   int          rd_seen = 0;
   int          bad_code = 99;
   int          valid_after = 0;
   logic [31:0] good_word = '0;
   logic [31:0] bad_word = '0;

   always @(negedge clk) begin
      if (!rst_n) bus_ack = 1'b0;
      else if (bus_ack) bus_ack = 1'b0;
      else if (bus_req) begin
         if (n_tx < LOGN) begin
            lg_addr[n_tx] = bus_addr; lg_data[n_tx] = bus_wdata;
            lg_we[n_tx] = bus_we; lg_cyc[n_tx] = cyc;
         end
         n_tx = n_tx + 1;
         if (bus_we) begin
            if (bus_addr == A_PNP) last_code = int'(bus_wdata);
            if (bus_addr == A_EN) rd_seen = 0;
            bus_rdata = '0;
         end else begin
            rd_seen = rd_seen + 1;
            bus_rdata = (last_code == bad_code || rd_seen <= valid_after) ? bad_word : good_word;
         end
         bus_ack = 1'b1;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [11:0] pt(input int i);
      return res_data[i*12 +: 12];
   endfunction

   task automatic cfg(input int a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a[4:0]; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic wait_upd(input int i, input string req);
      bit hit = 0;
      for (int k = 0; k < 2000 && !hit; k++) begin
         @(negedge clk);
         if (res_upd[i]) hit = 1;
      end
      chk(hit, req, "update pulse seen", hit, 1);
   endtask

   // cycle of the n-th sensor-mux write after base, or -1
   function automatic longint pnp_cyc(input int base, input int n);
      int seen = 0;
      for (int k = base; k < n_tx && k < LOGN; k++)
         if (lg_we[k] && lg_addr[k] == A_PNP) begin
            if (seen == n) return lg_cyc[k];
            seen++;
         end
      return -1;
   endfunction

   function automatic int pnp_code(input int base, input int n);
      int seen = 0;
      for (int k = base; k < n_tx && k < LOGN; k++)
         if (lg_we[k] && lg_addr[k] == A_PNP) begin
            if (seen == n) return int'(lg_data[k]);
            seen++;
         end
      return -1;
   endfunction

   task automatic t_reset;
      chk(res_data == '0, "R2", "reset results", res_data, 0);
      chk(res_err == '0, "R8", "reset errors", res_err, 0);
      chk(bus_req == 1'b0, "R10", "no request in reset", bus_req, 0);
   endtask

   task automatic t_full_sequence;
      int b;
      cfg(4, A_PNP); cfg(5, A_MUX); cfg(6, V_MUX); cfg(7, A_EN); cfg(8, V_EN);
      cfg(9, A_VLD); cfg(10, 32'h2C); cfg(11, 0); cfg(12, 2); cfg(13, 40);
      cfg(16, 0); cfg(17, 1); cfg(18, 2); cfg(19, 16);
      cfg(3, 3);
      valid_after = 0; good_word = 32'h0000_1ABC; bad_word = 32'h0;
      b = n_tx;
      cfg(2, 4'b1001);
      wait_upd(3, "R2");
      cfg(2, 0);
      chk(n_tx - b == 8, "R2", "transactions for points 0 and 3", n_tx - b, 8);
      chk(lg_addr[b] == A_PNP && lg_data[b] == 0, "R3", "point 0 code write", lg_data[b], 0);
      chk(lg_addr[b+1] == A_MUX && lg_data[b+1] == V_MUX, "R4", "channel write", lg_addr[b+1], A_MUX);
      chk(lg_addr[b+2] == A_EN && lg_data[b+2] == V_EN, "R4", "enable write", lg_addr[b+2], A_EN);
      chk(lg_addr[b+3] == A_VLD && !lg_we[b+3], "R5", "valid read", lg_addr[b+3], A_VLD);
      chk(lg_data[b+4] == 16, "R3", "point 3 code 16", lg_data[b+4], 16);
      chk(pt(0) == 12'hABC, "R5", "point 0 result", pt(0), 12'hABC);
      chk(pt(3) == 12'hABC, "R6", "point 3 result", pt(3), 12'hABC);
      chk(pt(1) == 12'h0, "R2", "point 1 untouched", pt(1), 0);
   endtask

   task automatic t_write_ctl;
      int b;
      cfg(3, 0); b = n_tx; cfg(2, 4'b0100);
      wait_upd(2, "R4"); cfg(2, 0);
      chk(n_tx - b == 2, "R4", "no mux writes: enable+read", n_tx - b, 2);
      chk(lg_addr[b] == A_EN, "R4", "enable first", lg_addr[b], A_EN);
      cfg(3, 1); b = n_tx; cfg(2, 4'b0100);
      wait_upd(2, "R3"); cfg(2, 0);
      chk(n_tx - b == 3, "R3", "code+enable+read", n_tx - b, 3);
      chk(lg_addr[b] == A_PNP && lg_data[b] == 2, "R3", "point 2 code", lg_data[b], 2);
      chk(lg_addr[b+1] == A_EN, "R4", "enable after code", lg_addr[b+1], A_EN);
   endtask

   task automatic t_poll_low_shift;
      int b;
      cfg(3, 0); cfg(10, 32'h1F); cfg(11, 4); cfg(12, 3);
      valid_after = 2; good_word = 32'h0003_4560; bad_word = 32'h8003_4560;
      b = n_tx; cfg(2, 4'b0100);
      wait_upd(2, "R7"); cfg(2, 0);
      chk(n_tx - b == 4, "R7", "three reads until valid", n_tx - b, 4);
      chk(lg_cyc[b+2] - lg_cyc[b+1] == 4, "R7", "poll spacing 1", lg_cyc[b+2] - lg_cyc[b+1], 4);
      chk(lg_cyc[b+3] - lg_cyc[b+2] == 4, "R7", "poll spacing 2", lg_cyc[b+3] - lg_cyc[b+2], 4);
      chk(pt(2) == 12'h456, "R6", "active-low valid, shift 4", pt(2), 12'h456);
      cfg(10, 32'h2C); cfg(11, 0); cfg(12, 2);
      valid_after = 0; bad_word = 32'h0;
   endtask

   task automatic t_timeout;
      cfg(3, 1); cfg(13, 20);
      bad_code = 0; good_word = 32'h0000_1123;
      cfg(2, 4'b0011);
      wait_upd(1, "R8"); cfg(2, 0);
      chk(res_err[0] == 1'b1, "R8", "error flag on timeout", res_err[0], 1);
      chk(pt(0) == 12'hABC, "R8", "result kept on timeout", pt(0), 12'hABC);
      chk(pt(1) == 12'h123, "R8", "next point measured", pt(1), 12'h123);
      chk(res_err[1] == 1'b0, "R8", "no error on good point", res_err[1], 0);
      bad_code = 99;
      cfg(2, 4'b0001);
      wait_upd(0, "R8"); cfg(2, 0);
      chk(res_err[0] == 1'b0, "R8", "error cleared by success", res_err[0], 0);
      chk(pt(0) == 12'h123, "R8", "result after recovery", pt(0), 12'h123);
   endtask

   task automatic t_period;
      int b;
      longint c0, c1;
      cfg(3, 1); cfg(0, 1); cfg(1, 2);
      b = n_tx; cfg(2, 4'b0001);
      repeat (1300) @(negedge clk);
      cfg(2, 0); repeat (40) @(negedge clk);
      c0 = pnp_cyc(b, 0); c1 = pnp_cyc(b, 1);
      chk(c0 >= 0 && c1 - c0 == 512, "R1", "period 1x2x256", c1 - c0, 512);
      cfg(0, 0); cfg(1, 1);
      b = n_tx; cfg(2, 4'b0001);
      repeat (700) @(negedge clk);
      cfg(2, 0); repeat (40) @(negedge clk);
      c0 = pnp_cyc(b, 0); c1 = pnp_cyc(b, 1);
      chk(c0 >= 0 && c1 - c0 == 256, "R1", "zero unit counts as one", c1 - c0, 256);
   endtask

   task automatic t_overlap;
      int b;
      longint c0, c2;
      cfg(3, 1); cfg(0, 1); cfg(1, 1); cfg(13, 400); cfg(12, 2);
      bad_code = 0;
      b = n_tx; cfg(2, 4'b0011);
      repeat (1400) @(negedge clk);
      cfg(2, 0);
      chk(pnp_code(b, 0) == 0 && pnp_code(b, 1) == 1, "R9", "first round order",
          pnp_code(b, 1), 1);
      chk(pnp_code(b, 2) == 0 && pnp_code(b, 3) == 1, "R9", "second round not restarted",
          pnp_code(b, 2), 0);
      c0 = pnp_cyc(b, 0); c2 = pnp_cyc(b, 2);
      chk(c2 - c0 == 512, "R9", "expiry during round skipped", c2 - c0, 512);
      chk(res_err[0] == 1'b1, "R8", "long timeout flags point 0", res_err[0], 1);
      repeat (600) @(negedge clk);
      bad_code = 99;
   endtask

   initial begin
      repeat (4) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_full_sequence();
      t_write_ctl();
      t_poll_low_shift();
      t_timeout();
      t_period();
      t_overlap();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #300000;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule